// File: doc/BRIEF.md
# Interrupt Request Qualifier

This block sits between a bank of level-sensitive interrupt request lines and the logic that picks and services interrupts. Every line passes through its own persistence filter: a request counts only once the line has been sampled high on a run of consecutive clock edges, so short noise pulses never reach the servicing logic. A request that survives the filter and whose enable bit is set is recorded in a pending register. That bit stays set until the servicing logic sends a one-cycle clear for that line.

A line held high produces exactly one pending event per qualification. After its bit is cleared, the line must go low and then complete a new qualifying run before the bit can set again. The enable mask is sampled on every cycle. It gates new events only and never removes a bit that is already pending. Priority selection and vector generation happen downstream.

Top module: `irq_req_qualifier`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pending bit and every persistence counter clears. After release, a line that was high throughout reset still needs a full fresh qualifying run.
- R2: A line sampled high on fewer than `QUAL_CYCLES` (default 3) consecutive rising edges never sets its pending bit. A low sample restarts the run from zero.
- R3: A line sampled high on `QUAL_CYCLES` consecutive rising edges, with its `mask_i` bit at 1 on the last of them, sets its `pend_o` bit at that last edge.
- R4: A pending bit stays set after its request line drops, for as long as no clear arrives.
- R5: A mask bit of 0 on the qualifying edge stops that line's pending bit from setting, however long the line stays high.
- R6: Changing a mask bit to 0 does not clear a pending bit that is already set.
- R7: A 1 on `clr_i[i]` at a rising edge clears `pend_o[i]` at that edge and leaves all other bits unchanged.
- R8: If a clear and a qualifying event for the same line meet on the same edge, the clear wins. A line that stays high after that does not set its bit again until it has gone low and completed a new qualifying run.
- R9: Lines qualify independently of each other. Bit i of `req_i`, `mask_i`, `clr_i` and `pend_o` all refer to the same line i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_LINES (15) | Level interrupt request lines |
| mask_i | input | NUM_LINES (15) | Per-line enable, 1 passes the line |
| clr_i | input | NUM_LINES (15) | Per-line clear pulse from servicing logic |
| pend_o | output | NUM_LINES (15) | Pending, enabled and qualified requests |

## Verification
The bench uses the default values: fifteen lines and a three-edge qualifying run. With these values both ends of the vector (line 0 and line 14) can be driven together, and the 2-bit counter runs all the way to saturation. The run length is short, so a bench can exercise the one-edge and two-edge near misses and the same-edge collision of a clear with a qualification at exact cycle positions. The run length is also long enough that a low sample in the middle of a run visibly restarts it.

// File: rtl/irq_qual_pkg.sv
// Package: shared helpers for the interrupt request qualifier.
// Assumes the qualifying run length is at least 1.
package irq_qual_pkg;

    // Width of a counter that must hold values 0 .. run_len.
    function automatic int cnt_width(input int run_len);
        return (run_len < 2) ? 1 : $clog2(run_len + 1);
    endfunction

endpackage

// File: rtl/irq_persist_filter.sv
// Module: persistence filter for one request line.
// A saturating counter counts the consecutive rising edges on which the line
// is high, and goes back to zero on any low sample. fire_o pulses for one
// cycle, on the edge that completes the run. A line held high after that does
// not fire again until it has gone low and qualified once more.
// Assumes QUAL_CYCLES >= 1 and that req_i is already synchronous to clk.
module irq_persist_filter #(
    parameter int QUAL_CYCLES = 3,
    parameter int CW          = irq_qual_pkg::cnt_width(QUAL_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic fire_o
);
    localparam logic [CW-1:0] LAST_CNT = CW'(QUAL_CYCLES - 1);
    localparam logic [CW-1:0] SAT_CNT  = CW'(QUAL_CYCLES);

    logic [CW-1:0] cnt_q;

    // Count consecutive high samples, saturating once the run is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!req_i) begin
            cnt_q <= '0;
        end else if (cnt_q != SAT_CNT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fire on the sample that completes the run.
    assign fire_o = req_i && (cnt_q == LAST_CNT);

    // A nonzero count can only follow a high sample on the previous edge.
    p_count_needs_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $past(req_i));

    // One qualification gives one pulse, never two pulses in a row.
    p_single_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);

endmodule

// File: rtl/irq_pend_bank.sv
// Module: pending register bank.
// Records qualified events that are enabled, and drops bits on clear pulses.
// If a clear and a set land on the same edge for one bit, the clear wins.
// The mask gates only new sets; it never removes a bit that is already pending.
// Assumes fire_i comes from filters that pulse for a single cycle.
module irq_pend_bank #(
    parameter int NUM_LINES = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] fire_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] pend_o
);
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] set_vec;

    // Only enabled lines can set a pending bit.
    assign set_vec = fire_i & mask_i;

    // Set, then clear; clear has the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q | set_vec) & ~clr_i;
        end
    end

    assign pend_o = pend_q;

    // The edge after reset shows an empty register.
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pend_q == '0));

    // A bit rises only after a filter pulse on that line.
    p_set_needs_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(fire_i)) == '0);

    // A bit holds unless its clear was seen.
    p_hold_until_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q) & ~$past(clr_i) & ~pend_q) == '0);

    // A masked line never rises.
    p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~$past(pend_q) & ~$past(mask_i)) == '0);

    // After a clear the bit reads low, even if a set landed on the same edge.
    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0));

endmodule

// File: rtl/irq_req_qualifier.sv
// Module: interrupt request qualifier (top).
// Gives every request line its own persistence filter, and feeds the filter
// pulses through the mask into the pending register bank.
// Assumes req_i lines are already synchronous to clk, and that the servicing
// logic pulses clr_i for one cycle per serviced line.
module irq_req_qualifier #(
    parameter int NUM_LINES   = 15,
    parameter int QUAL_CYCLES = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_i,
    input  logic [NUM_LINES-1:0] mask_i,
    input  logic [NUM_LINES-1:0] clr_i,
    output logic [NUM_LINES-1:0] pend_o
);
    localparam int CW = irq_qual_pkg::cnt_width(QUAL_CYCLES);

    logic [NUM_LINES-1:0] fire_vec;

    // One persistence filter for each request line.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        irq_persist_filter #(
            .QUAL_CYCLES(QUAL_CYCLES),
            .CW         (CW)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req_i[i]),
            .fire_o(fire_vec[i])
        );
    end

    irq_pend_bank #(
        .NUM_LINES(NUM_LINES)
    ) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .fire_i(fire_vec),
        .mask_i(mask_i),
        .clr_i (clr_i),
        .pend_o(pend_o)
    );

    // The output changes only by a set on a line whose request was high, or by a clear.
    p_rise_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o & ~$past(pend_o) & ~$past(req_i)) == '0);

endmodule

// File: tb/tb_irq_req_qualifier.sv
// Directed bench for irq_req_qualifier. Inputs change and outputs are
// sampled on falling edges, half a period away from the active edge.
module tb_irq_req_qualifier;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] mask = '0;
    logic [N-1:0] clr = '0;
    logic [N-1:0] pend;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_req_qualifier #(.NUM_LINES(N), .QUAL_CYCLES(3)) dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask),
        .clr_i(clr), .pend_o(pend)
    );

    // Advance n rising edges and stop at the following falling edge.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [N-1:0] exp);
        n_tests++;
        if (pend !== exp) begin
            n_fail++;
            $display("FAIL %s: pend=%h expected %h", tag, pend, exp);
        end
    endtask

    // Reset with all lines high; release must need a fresh run.
    task automatic t_reset;
        req = '1; mask = '1; clr = '0; rst_n = 1'b0;
        step(4);
        check("R1 pend empty in reset", '0);
        rst_n = 1'b1;
        step(2);
        check("R1 counters restarted", '0);
        step(1);
        check("R1 fresh run qualifies", '1);
        req = '0; clr = '1; step(1); clr = '0;
        check("R7 clear all", '0);
    endtask

    // Short pulses and interrupted runs never set.
    task automatic t_short;
        req[3] = 1'b1; step(1); req[3] = 1'b0; step(2);
        req[5] = 1'b1; step(2); req[5] = 1'b0; step(2);
        check("R2 one- and two-edge pulses", '0);
        req[6] = 1'b1; step(2); req[6] = 1'b0; step(1);
        req[6] = 1'b1; step(2);
        check("R2 low sample restarts run", '0);
        step(1);
        check("R2 full run after restart", 15'h0040);
        req = '0; clr[6] = 1'b1; step(1); clr = '0;
    endtask

    // Two far lines qualify together, then hold after dropping.
    task automatic t_qualify;
        req[0] = 1'b1; req[14] = 1'b1;
        step(2);
        check("R3 not yet at second edge", '0);
        step(1);
        check("R3 R9 set at third edge", 15'h4001);
        req = '0; step(4);
        check("R4 holds after drop", 15'h4001);
        clr[0] = 1'b1; step(1); clr = '0;
        check("R7 clear one line only", 15'h4000);
        clr[14] = 1'b1; step(1); clr = '0;
        check("R7 clear top line", '0);
    endtask

    // Masked line never sets; masking a pending bit leaves it.
    task automatic t_mask;
        mask[7] = 1'b0; req[7] = 1'b1; step(5);
        check("R5 masked line blocked", '0);
        mask[7] = 1'b1; step(2);
        check("R5 late enable gives no set while held", '0);
        req[7] = 1'b0; step(1);
        req[9] = 1'b1; step(3);
        check("R6 line 9 pending", 15'h0200);
        req[9] = 1'b0; mask[9] = 1'b0; step(3);
        check("R6 mask keeps pending bit", 15'h0200);
        mask = '1; clr[9] = 1'b1; step(1); clr = '0;
        check("R7 line 9 cleared", '0);
    endtask

    // Clear meets qualification on the same edge.
    task automatic t_collide;
        req[2] = 1'b1; step(2);
        clr[2] = 1'b1; step(1); clr = '0;
        check("R8 clear wins collision", '0);
        step(5);
        check("R8 held line does not refire", '0);
        req[2] = 1'b0; step(1);
        req[2] = 1'b1; step(3);
        check("R8 fresh run sets again", 15'h0004);
        req = '0; clr[2] = 1'b1; step(1); clr = '0;
        check("R7 line 2 cleared", '0);
    endtask

    initial begin
        t_reset;
        t_short;
        t_qualify;
        t_mask;
        t_collide;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule